// File: doc/BRIEF.md
# Word-Serial Operand Store with Carry-In Bit

This block holds big-number operands for a datapath that walks each operand one word at a time. Every operand takes up a fixed run of consecutive word slots. Its least-significant word sits at the lowest address of the run. A controller writes words through a single port. It reads two words per cycle through two independent ports, for example one port per source operand of an add-and-shift step.

Each read port returns the addressed word and one extra bit. That bit is the lowest bit of the word one slot above, within the same operand. A datapath that is one bit wider than a word can then do a right shift of the whole operand one word at a time. The bit entering the top of each word is the true neighbour bit, not a copy of the word's own top bit. When the addressed word is the topmost word of its operand, the extra bit is zero. The number of slots actually built can be smaller than the address space allows. Addresses past the last built slot read as zero and cannot be written.

Top module: `ovr_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, both read ports show all-zero word and zero carry bit after that edge. Reset does not alter stored words.
- R2: A word written at one edge (`wr_en` high, `wr_addr` < NUM_WORDS) is returned by a port whose address names that slot at the next edge. Read data is registered, so it appears one edge after the address is presented.
- R3: For an address inside an operand but not its topmost word, the carry bit equals bit 0 of the word at address+1. Operand k occupies addresses k*OPND_WORDS to k*OPND_WORDS+OPND_WORDS-1.
- R4: For the topmost word of an operand (address mod OPND_WORDS = OPND_WORDS-1), the carry bit is 0 whatever the next slot holds.
- R5: The carry bit never follows bit WORD_W-1 of the addressed word. A word with its top bit set beside a neighbour with bit 0 clear gives carry 0.
- R6: When a read and a write hit the same slot at the same edge, the read returns the value held before that write. This also holds for the carry bit when the write hits address+1.
- R7: A write with `wr_addr` >= NUM_WORDS changes no stored word.
- R8: A read with address >= NUM_WORDS returns an all-zero word and a zero carry bit.
- R9: The two read ports work independently and at the same time on any pair of addresses, including the same address.
- R10: With `wr_en` low, `wr_data` and `wr_addr` have no effect on stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all reads and writes act on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the read output registers |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write slot address |
| wr_data | input | WORD_W | Word to store |
| rd0_addr | input | ADDR_W | Read port 0 address |
| rd0_data | output | WORD_W | Read port 0 word |
| rd0_ovl | output | 1 | Read port 0 carry bit (bit 0 of the next word of the operand) |
| rd1_addr | input | ADDR_W | Read port 1 address |
| rd1_data | output | WORD_W | Read port 1 word |
| rd1_ovl | output | 1 | Read port 1 carry bit |

## Verification
The hardest case to reach is a read whose carry bit comes from a slot being overwritten at the same edge. The carry bit must still show the old bit 0 of the neighbour, while a plain read of the neighbour shows the new value one edge later. The bench drives a write to slot 4 together with reads of slot 4 and slot 3 in one cycle. The old and new values differ in bit 0, so a forwarding or ordering fault changes the result. It also pairs words whose top bit is set with neighbours whose bit 0 is clear, which exposes any carry taken from the wrong bit. It then walks every operand boundary and the unbuilt addresses at the top of the map.

// File: rtl/ovr_rf_pkg.sv
package ovr_rf_pkg;

    // Classification of a word address against the built map
    typedef struct packed {
        logic hit;   // address names a built slot
        logic top;   // slot is the most-significant word of its operand
    } addr_class_t;

    function automatic addr_class_t classify(input int unsigned a,
                                             input int unsigned num_words,
                                             input int unsigned opnd_words);
        addr_class_t c;
        c.hit = (a < num_words);
        c.top = ((a % opnd_words) == (opnd_words - 1));
        return c;
    endfunction

endpackage

// File: rtl/ovr_rf_store.sv
module ovr_rf_store #(
    parameter int WORD_W    = 8,
    parameter int ADDR_W    = 4,
    parameter int NUM_WORDS = 12
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] mem_q [NUM_WORDS]
);

    // One enable per built slot; unbuilt addresses decode to nothing
    generate
        for (genvar i = 0; i < NUM_WORDS; i++) begin : g_slot
            logic sel;
            assign sel = wr_en && (wr_addr == ADDR_W'(i));
            always_ff @(posedge clk) begin
                if (sel) begin
                    mem_q[i] <= wr_data;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/ovr_rf_rdport.sv
module ovr_rf_rdport
    import ovr_rf_pkg::*;
#(
    parameter int WORD_W     = 8,
    parameter int ADDR_W     = 4,
    parameter int NUM_WORDS  = 12,
    parameter int OPND_WORDS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] mem_i [NUM_WORDS],
    input  logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] data_o,
    output logic              ovl_o
);

    addr_class_t       cls;
    logic [WORD_W-1:0] word_c;
    logic              nxt_lsb_c;
    logic              ovl_c;

    always_comb begin
        cls = classify(32'(addr), NUM_WORDS, OPND_WORDS);
    end

    // Word select over built slots only
    always_comb begin
        word_c = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (addr == ADDR_W'(i)) begin
                word_c = mem_i[i];
            end
        end
    end

    // Bit 0 of the slot above the addressed one
    always_comb begin
        nxt_lsb_c = 1'b0;
        for (int i = 0; i < NUM_WORDS - 1; i++) begin
            if (addr == ADDR_W'(i)) begin
                nxt_lsb_c = mem_i[i+1][0];
            end
        end
    end

    assign ovl_c = cls.hit && !cls.top && nxt_lsb_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_o <= '0;
            ovl_o  <= 1'b0;
        end else begin
            data_o <= word_c;
            ovl_o  <= ovl_c;
        end
    end

endmodule

// File: rtl/ovr_regfile.sv
module ovr_regfile #(
    parameter int WORD_W     = 8,
    parameter int ADDR_W     = 4,
    parameter int NUM_WORDS  = 12,
    parameter int OPND_WORDS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd0_addr,
    output logic [WORD_W-1:0] rd0_data,
    output logic              rd0_ovl,
    input  logic [ADDR_W-1:0] rd1_addr,
    output logic [WORD_W-1:0] rd1_data,
    output logic              rd1_ovl
);

    localparam int NUM_RD = 2;

    logic [WORD_W-1:0] mem   [NUM_WORDS];
    logic [ADDR_W-1:0] rd_a  [NUM_RD];
    logic [WORD_W-1:0] rd_d  [NUM_RD];
    logic              rd_o  [NUM_RD];

    assign rd_a[0]  = rd0_addr;
    assign rd_a[1]  = rd1_addr;
    assign rd0_data = rd_d[0];
    assign rd0_ovl  = rd_o[0];
    assign rd1_data = rd_d[1];
    assign rd1_ovl  = rd_o[1];

    ovr_rf_store #(
        .WORD_W   (WORD_W),
        .ADDR_W   (ADDR_W),
        .NUM_WORDS(NUM_WORDS)
    ) u_store (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .mem_q  (mem)
    );

    generate
        for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
            ovr_rf_rdport #(
                .WORD_W    (WORD_W),
                .ADDR_W    (ADDR_W),
                .NUM_WORDS (NUM_WORDS),
                .OPND_WORDS(OPND_WORDS)
            ) u_port (
                .clk   (clk),
                .rst   (rst),
                .mem_i (mem),
                .addr  (rd_a[p]),
                .data_o(rd_d[p]),
                .ovl_o (rd_o[p])
            );
        end
    endgenerate

endmodule

// File: rtl/ovr_regfile_chk.sv
module ovr_regfile_chk #(
    parameter int WORD_W     = 8,
    parameter int ADDR_W     = 4,
    parameter int NUM_WORDS  = 12,
    parameter int OPND_WORDS = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [WORD_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd0_addr,
    input logic [WORD_W-1:0] rd0_data,
    input logic              rd0_ovl,
    input logic [ADDR_W-1:0] rd1_addr,
    input logic [WORD_W-1:0] rd1_data,
    input logic              rd1_ovl
);

    logic unused_w;
    assign unused_w = ^{wr_addr, wr_data};

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (rd0_data == '0 && !rd0_ovl && rd1_data == '0 && !rd1_ovl)); // R1

    AST_TOP_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        ((32'(rd0_addr) % OPND_WORDS) == OPND_WORDS - 1) |=> !rd0_ovl); // R4

    AST_OOR_READ0_ZERO: assert property (@(posedge clk) disable iff (rst)
        (32'(rd0_addr) >= NUM_WORDS) |=> (rd0_data == '0 && !rd0_ovl)); // R8

    AST_OOR_READ1_ZERO: assert property (@(posedge clk) disable iff (rst)
        (32'(rd1_addr) >= NUM_WORDS) |=> (rd1_data == '0 && !rd1_ovl)); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (rd0_addr == $past(rd0_addr) && !$past(wr_en) && !$past(rst))
        |=> ($stable(rd0_data) && $stable(rd0_ovl))); // R10

endmodule

bind ovr_regfile ovr_regfile_chk #(
    .WORD_W    (WORD_W),
    .ADDR_W    (ADDR_W),
    .NUM_WORDS (NUM_WORDS),
    .OPND_WORDS(OPND_WORDS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd0_addr(rd0_addr),
    .rd0_data(rd0_data),
    .rd0_ovl (rd0_ovl),
    .rd1_addr(rd1_addr),
    .rd1_data(rd1_data),
    .rd1_ovl (rd1_ovl)
);

// File: tb/ovr_regfile_tb.sv
module ovr_regfile_tb;

    localparam int W  = 8;
    localparam int AW = 4;
    localparam int N  = 12;
    localparam int OW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [AW-1:0] rd0_addr = '0;
    logic [AW-1:0] rd1_addr = '0;
    logic [W-1:0]  rd0_data, rd1_data;
    logic          rd0_ovl, rd1_ovl;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [W-1:0] model [N];

    always #5 clk = ~clk;

    ovr_regfile #(.WORD_W(W), .ADDR_W(AW), .NUM_WORDS(N), .OPND_WORDS(OW)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd0_addr(rd0_addr), .rd0_data(rd0_data), .rd0_ovl(rd0_ovl),
        .rd1_addr(rd1_addr), .rd1_data(rd1_data), .rd1_ovl(rd1_ovl)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_word(input int a);
        return (a < N) ? model[a] : '0;
    endfunction

    function automatic logic exp_ovl(input int a);
        if (a >= N || (a % OW) == OW - 1) return 1'b0;
        return model[a+1][0];
    endfunction

    // one write, issued at a negedge, lands at the following posedge
    task automatic wr(input int a, input logic [W-1:0] d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < N) model[a] = d;
    endtask

    task automatic rd_check(input string req, input int a0, input int a1);
        rd0_addr = AW'(a0); rd1_addr = AW'(a1);
        @(negedge clk);
        chk(req, rd0_data, exp_word(a0));
        chk(req, rd0_ovl,  exp_ovl(a0));
        chk(req, rd1_data, exp_word(a1));
        chk(req, rd1_ovl,  exp_ovl(a1));
    endtask

    task automatic t_reset();
        chk("R1", rd0_data, 0); chk("R1", rd0_ovl, 0);
        chk("R1", rd1_data, 0); chk("R1", rd1_ovl, 0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < N; i++) wr(i, W'(8'h35 + i * 8'h2B));
        for (int i = 0; i < N; i++) rd_check("R2_R3_R9", i, N - 1 - i);
        rd_check("R9", 5, 5);
    endtask

    task automatic t_boundary();
        wr(2, 8'h00); wr(3, 8'hFF);
        rd_check("R4", 2, 1);
        wr(11, 8'h01);
        rd_check("R4", 11, 10);
        wr(7, 8'h03);
        rd_check("R3", 6, 8);
    endtask

    task automatic t_msb();
        wr(0, 8'h80); wr(1, 8'hFE);
        rd_check("R5", 0, 1);
        wr(0, 8'h7F); wr(1, 8'h01);
        rd_check("R5", 0, 1);
    endtask

    task automatic t_rbw();
        logic [W-1:0] old4;
        logic         old_ovl3;
        wr(4, 8'hA2);
        rd_check("R6", 4, 3);
        old4 = model[4]; old_ovl3 = exp_ovl(3);
        wr_en = 1'b1; wr_addr = AW'(4); wr_data = 8'h5D;
        rd0_addr = AW'(4); rd1_addr = AW'(3);
        @(negedge clk);
        wr_en = 1'b0; model[4] = 8'h5D;
        chk("R6", rd0_data, old4);
        chk("R6", rd1_ovl,  old_ovl3);
        @(negedge clk);
        chk("R6", rd0_data, 8'h5D);
        chk("R6", rd1_ovl,  1);
    endtask

    task automatic t_oor();
        wr(13, 8'hFF); wr(12, 8'hEE); wr(15, 8'hC3);
        for (int i = 0; i < N; i++) rd_check("R7", i, i);
        rd_check("R8", 12, 15);
        rd_check("R8", 13, 14);
    endtask

    task automatic t_no_wen();
        wr_en = 1'b0; wr_addr = AW'(6); wr_data = ~model[6];
        @(negedge clk);
        wr_addr = AW'(7); wr_data = ~model[7];
        @(negedge clk);
        rd_check("R10", 6, 7);
    endtask

    task automatic t_reset_mid();
        rd0_addr = AW'(1); rd1_addr = AW'(6);
        rst = 1'b1;
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        rd_check("R1", 1, 6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_fill();
        t_boundary();
        t_msb();
        t_rbw();
        t_oor();
        t_no_wen();
        t_reset_mid();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule